// File: doc/BRIEF.md
# Ethernet MAC Control Register File

This block holds the 16-bit control and status words of an Ethernet MAC. Software reaches them over a simple register port: a 12-bit byte offset, one-cycle read and write strobes, write data, and read data that is registered and valid in the cycle after the read strobe. Words sit on 16-byte boundaries. The block decodes each offset and applies the side effect of each access. The global status word and the peak-attempts word clear when they are read. The transmit soft reset clears itself. A FIFO control write is turned into an enable and a size in bytes.

Status events come in on a vector and collect in the global status word. An interrupt is raised for every pending status bit whose mask bit is 0. The mask is inverted: a 1 in the mask blocks the event, and the mask comes out of reset as all ones. Attempt samples from the transmitter are compared against the stored peak, which keeps the largest value seen. The station address words and the multicast hash words are brought out as flat vectors for the filtering logic. The collision and receive-error counters can be loaded and read back by software. Their increment sources live outside this block.

Top module: `emac_regfile`

## Requirements
- R1: After reset the mask word (0x210) reads 0xFFFF, the status word (0x200) reads 0, every read-write word reads 0, the interrupt is low, and both FIFO sizes report 128.
- R2: A read strobe at offset A loads rdata at the next clock edge. Read-write words return the last value written, masked to their width: the transmit threshold (0x110) keeps 8 bits, and the FIFO control words keep bits 8:0.
- R3: Reading the status word returns its contents and clears it. Status input bits OR into the word and stay set until a read.
- R4: A status input bit that arrives in the same cycle as a clearing read is kept in the word after the read.
- R5: The 8-bit peak word (0x4E0) keeps the largest attempt sample seen and clears when read. A sample that arrives in the same cycle as that read is kept.
- R6: irq is high exactly when some status bit is 1 and the mask bit at the same position is 0.
- R7: In a FIFO control write (transmit 0x100, receive 0x120), bit 0 is the enable and bits 8:1 are a field F. The size output is (F+1)*128.
- R8: Writing 1 to bit 0 of 0x420 drives tx_sw_rst high for exactly one cycle. The word then reads 0.
- R9: The station address words at 0x660, 0x670 and 0x680 hold indices 2, 1 and 0. Word index i drives station_addr[16i+15:16i].
- R10: The hash words at 0x700, 0x710, 0x720 and 0x730 hold indices 0 to 3 (taken from offset bits 5:4). Word index i drives hash_bits[16i+15:16i].
- R11: The counters at 0x500, 0x510, 0x520, 0x530, 0x690 and the seed at 0x540 keep 16 bits. The counters at 0x6A0, 0x6B0, 0x6C0 and 0x6E0 keep 8 bits.
- R12: 0x170 always reads the CHIP_ID parameter, and writes to it have no effect.
- R13: Offsets that are not mapped read 0, and writes to them change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Register byte offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| stat_set | input | 16 | Status event pulses, ORed into the status word |
| att_valid | input | 1 | Attempt sample valid |
| att_val | input | 8 | Attempt count sample |
| irq | output | 1 | Interrupt: some unmasked status bit is set |
| tx_fifo_en | output | 1 | Transmit FIFO enable |
| tx_fifo_size | output | 16 | Transmit FIFO size in bytes |
| rx_fifo_en | output | 1 | Receive FIFO enable |
| rx_fifo_size | output | 16 | Receive FIFO size in bytes |
| tx_sw_rst | output | 1 | One-cycle transmit soft reset pulse |
| station_addr | output | 48 | Station address filter words |
| hash_bits | output | 64 | Multicast hash table words |

## Verification
A status or peak word that clears at the wrong moment shows at the ports within two cycles. Either an event bit is missing on the next read, or irq drops while an unmasked bit should still be pending. A wrong filter or hash index puts a word in the wrong slice of station_addr or hash_bits in the cycle after the write. A bad FIFO decode shows at once on the size outputs. A width or decode fault shows on the next readback: an unmapped write can corrupt a real word, and an 8-bit counter can keep high bits it should drop.

// File: rtl/emac_reg_pkg.sv
package emac_reg_pkg;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int FIFO_UNIT_LOG2 = 7;
  localparam int NCNT = 9;
  localparam int WIDE_CNTS = 5;

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] word_t;

  localparam addr_t OFS_XIFC    = 12'h000;
  localparam addr_t OFS_TXFIFO  = 12'h100;
  localparam addr_t OFS_TXTH    = 12'h110;
  localparam addr_t OFS_RXFIFO  = 12'h120;
  localparam addr_t OFS_CHIPID  = 12'h170;
  localparam addr_t OFS_GSTAT   = 12'h200;
  localparam addr_t OFS_EVMASK  = 12'h210;
  localparam addr_t OFS_TXRST   = 12'h420;
  localparam addr_t OFS_TXCFG   = 12'h430;
  localparam addr_t OFS_PEAK    = 12'h4E0;
  localparam addr_t OFS_SEED    = 12'h540;
  localparam addr_t OFS_RXCFG   = 12'h630;
  localparam addr_t OFS_FILT_HI = 12'h660;
  localparam addr_t OFS_FILT_MD = 12'h670;
  localparam addr_t OFS_FILT_LO = 12'h680;

  // FIFO size in bytes from the 8-bit size field
  function automatic word_t fifo_bytes(input logic [7:0] fld);
    logic [31:0] v;
    v = (32'(fld) + 32'd1) << FIFO_UNIT_LOG2;
    return v[DW-1:0];
  endfunction

  // station address word index: 8 minus offset bits 7:4
  function automatic logic [1:0] filt_index(input addr_t a);
    logic [3:0] d;
    d = 4'd8 - a[7:4];
    return d[1:0];
  endfunction

  function automatic logic is_filt(input addr_t a);
    return (a == OFS_FILT_HI) || (a == OFS_FILT_MD) || (a == OFS_FILT_LO);
  endfunction

  function automatic logic is_hash(input addr_t a);
    return (a[11:6] == 6'h1C) && (a[3:0] == 4'h0);
  endfunction

  function automatic addr_t cnt_offset(input int i);
    case (i)
      0: return 12'h500;
      1: return 12'h510;
      2: return 12'h520;
      3: return 12'h530;
      4: return 12'h690;
      5: return 12'h6A0;
      6: return 12'h6B0;
      7: return 12'h6C0;
      default: return 12'h6E0;
    endcase
  endfunction
endpackage

// File: rtl/emac_status_unit.sv
module emac_status_unit
  import emac_reg_pkg::*;
#(
  parameter int PEAK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  addr_t             addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  word_t             wdata,
  input  word_t             stat_set,
  input  logic              att_valid,
  input  logic [PEAK_W-1:0] att_val,
  output logic              rd_hit,
  output word_t             rd_word,
  output logic              irq
);
  word_t             stat_q, mask_q, pending;
  logic [PEAK_W-1:0] peak_q, peak_base;
  logic              stat_rd, peak_rd, mask_wr;

  assign stat_rd   = rd_en && (addr == OFS_GSTAT);
  assign peak_rd   = rd_en && (addr == OFS_PEAK);
  assign mask_wr   = wr_en && (addr == OFS_EVMASK);
  assign peak_base = peak_rd ? '0 : peak_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
      peak_q <= '0;
    end else begin
      stat_q <= (stat_rd ? '0 : stat_q) | stat_set;
      if (mask_wr) mask_q <= wdata;
      if (att_valid && (att_val > peak_base)) peak_q <= att_val;
      else                                    peak_q <= peak_base;
    end
  end

  assign pending = stat_q & ~mask_q;
  assign irq     = |pending;

  always_comb begin
    rd_hit  = 1'b1;
    rd_word = '0;
    case (addr)
      OFS_GSTAT:  rd_word = stat_q;
      OFS_EVMASK: rd_word = mask_q;
      OFS_PEAK:   rd_word = DW'(peak_q);
      default:    rd_hit  = 1'b0;
    endcase
  end

  a_r3_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && stat_set == '0) |=> stat_q == '0);
  a_r4_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (stat_q & $past(stat_set)) == $past(stat_set));
  a_r5_peak_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !peak_rd |=> peak_q >= $past(peak_q));
  a_r6_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);
endmodule

// File: rtl/emac_cfg_bank.sv
module emac_cfg_bank
  import emac_reg_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  addr_t        addr,
  input  logic         wr_en,
  input  word_t        wdata,
  output logic         rd_hit,
  output word_t        rd_word,
  output logic         tx_fifo_en,
  output word_t        tx_fifo_size,
  output logic         rx_fifo_en,
  output word_t        rx_fifo_size,
  output logic         tx_sw_rst,
  output logic [47:0]  station_addr,
  output logic [63:0]  hash_bits
);
  word_t       xifc_q, txcfg_q, rxcfg_q, seed_q;
  logic [7:0]  txth_q;
  logic [8:0]  txfifo_q, rxfifo_q;
  logic        txrst_q, txrst_wr;
  word_t       filt_q [3];
  word_t       hash_q [4];

  assign txrst_wr = wr_en && (addr == OFS_TXRST) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xifc_q   <= '0;
      txcfg_q  <= '0;
      rxcfg_q  <= '0;
      seed_q   <= '0;
      txth_q   <= '0;
      txfifo_q <= '0;
      rxfifo_q <= '0;
      txrst_q  <= 1'b0;
    end else begin
      txrst_q <= txrst_wr;
      if (wr_en) begin
        case (addr)
          OFS_XIFC:   xifc_q   <= wdata;
          OFS_TXCFG:  txcfg_q  <= wdata;
          OFS_RXCFG:  rxcfg_q  <= wdata;
          OFS_SEED:   seed_q   <= wdata;
          OFS_TXTH:   txth_q   <= wdata[7:0];
          OFS_TXFIFO: txfifo_q <= wdata[8:0];
          OFS_RXFIFO: rxfifo_q <= wdata[8:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_filt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) filt_q[g] <= '0;
      else if (wr_en && is_filt(addr) && filt_index(addr) == 2'(g))
        filt_q[g] <= wdata;
    end
    assign station_addr[16*g +: 16] = filt_q[g];
  end

  for (genvar g = 0; g < 4; g++) begin : g_hash
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hash_q[g] <= '0;
      else if (wr_en && is_hash(addr) && addr[5:4] == 2'(g))
        hash_q[g] <= wdata;
    end
    assign hash_bits[16*g +: 16] = hash_q[g];
  end

  assign tx_fifo_en   = txfifo_q[0];
  assign rx_fifo_en   = rxfifo_q[0];
  assign tx_fifo_size = fifo_bytes(txfifo_q[8:1]);
  assign rx_fifo_size = fifo_bytes(rxfifo_q[8:1]);
  assign tx_sw_rst    = txrst_q;

  always_comb begin
    rd_hit  = 1'b1;
    rd_word = '0;
    if (is_filt(addr))      rd_word = filt_q[filt_index(addr)];
    else if (is_hash(addr)) rd_word = hash_q[addr[5:4]];
    else begin
      case (addr)
        OFS_XIFC:   rd_word = xifc_q;
        OFS_TXCFG:  rd_word = txcfg_q;
        OFS_RXCFG:  rd_word = rxcfg_q;
        OFS_SEED:   rd_word = seed_q;
        OFS_TXTH:   rd_word = DW'(txth_q);
        OFS_TXFIFO: rd_word = DW'(txfifo_q);
        OFS_RXFIFO: rd_word = DW'(rxfifo_q);
        OFS_TXRST:  rd_word = DW'(txrst_q);
        default:    rd_hit  = 1'b0;
      endcase
    end
  end

  a_r7_size_granule: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_size[FIFO_UNIT_LOG2-1:0] == '0 && rx_fifo_size != '0);
  a_r8_reset_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sw_rst && !txrst_wr) |=> !tx_sw_rst);
  a_r8_reset_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_sw_rst) |-> $past(wr_en));
endmodule

// File: rtl/emac_counter_bank.sv
module emac_counter_bank
  import emac_reg_pkg::*;
#(
  parameter int SMALL_W = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t addr,
  input  logic  wr_en,
  input  word_t wdata,
  output logic  rd_hit,
  output word_t rd_word
);
  logic [NCNT-1:0] hit;
  word_t           word [NCNT];

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    localparam int W = (g < WIDE_CNTS) ? DW : SMALL_W;
    logic [W-1:0] q;
    assign hit[g] = (addr == cnt_offset(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               q <= '0;
      else if (wr_en && hit[g]) q <= wdata[W-1:0];
    end
    assign word[g] = DW'(q);
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NCNT; i++)
      if (hit[i]) rd_word = word[i];
  end
  assign rd_hit = |hit;

  a_r11_single_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/emac_regfile.sv
module emac_regfile
  import emac_reg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID = 16'h0001,
  parameter int          PEAK_W  = 8,
  parameter int          SMALL_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] addr,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic [15:0] stat_set,
  input  logic        att_valid,
  input  logic [7:0]  att_val,
  output logic        irq,
  output logic        tx_fifo_en,
  output logic [15:0] tx_fifo_size,
  output logic        rx_fifo_en,
  output logic [15:0] rx_fifo_size,
  output logic        tx_sw_rst,
  output logic [47:0] station_addr,
  output logic [63:0] hash_bits
);
  logic  st_hit, cfg_hit, cnt_hit, id_hit, any_hit;
  word_t st_word, cfg_word, cnt_word, id_word, rd_next, rdata_q;

  emac_status_unit #(.PEAK_W(PEAK_W)) u_status (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .stat_set(stat_set), .att_valid(att_valid),
    .att_val(att_val[PEAK_W-1:0]), .rd_hit(st_hit), .rd_word(st_word), .irq(irq)
  );

  emac_cfg_bank u_cfg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_hit(cfg_hit), .rd_word(cfg_word),
    .tx_fifo_en(tx_fifo_en), .tx_fifo_size(tx_fifo_size),
    .rx_fifo_en(rx_fifo_en), .rx_fifo_size(rx_fifo_size),
    .tx_sw_rst(tx_sw_rst), .station_addr(station_addr), .hash_bits(hash_bits)
  );

  emac_counter_bank #(.SMALL_W(SMALL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_hit(cnt_hit), .rd_word(cnt_word)
  );

  assign id_hit  = (addr == OFS_CHIPID);
  assign id_word = id_hit ? CHIP_ID : '0;
  assign any_hit = st_hit | cfg_hit | cnt_hit | id_hit;
  assign rd_next = st_word | cfg_word | cnt_word | id_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_next;
  end
  assign rdata = rdata_q;

  a_r13_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !any_hit) |=> rdata == '0);
  a_r12_chip_id: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && id_hit) |=> rdata == CHIP_ID);
  a_r2_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st_hit, cfg_hit, cnt_hit, id_hit}) <= 1);
endmodule

// File: tb/emac_regfile_test.sv
module emac_regfile_test;
  localparam logic [15:0] ID = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, att_valid = 1'b0;
  logic [15:0] wdata = '0, stat_set = '0;
  logic [7:0]  att_val = '0;
  logic [15:0] rdata, tx_fifo_size, rx_fifo_size;
  logic        irq, tx_fifo_en, rx_fifo_en, tx_sw_rst;
  logic [47:0] station_addr;
  logic [63:0] hash_bits;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  emac_regfile #(.CHIP_ID(ID)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .stat_set(stat_set), .att_valid(att_valid),
    .att_val(att_val), .irq(irq), .tx_fifo_en(tx_fifo_en),
    .tx_fifo_size(tx_fifo_size), .rx_fifo_en(rx_fifo_en),
    .rx_fifo_size(rx_fifo_size), .tx_sw_rst(tx_sw_rst),
    .station_addr(station_addr), .hash_bits(hash_bits)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] size_of(input logic [7:0] f);
    return 16'((int'(f) + 1) * 128);
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic test_reset();
    logic [15:0] d;
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 tx size", 64'(tx_fifo_size), 64'd128);
    chk("R1 rx size", 64'(rx_fifo_size), 64'd128);
    rd(12'h210, d); chk("R1 mask", 64'(d), 64'hFFFF);
    rd(12'h200, d); chk("R1 status", 64'(d), 64'd0);
    rd(12'h630, d); chk("R1 rx cfg", 64'(d), 64'd0);
  endtask

  task automatic test_rw();
    logic [15:0] d;
    wr(12'h000, 16'hC3A5); rd(12'h000, d); chk("R2 xifc", 64'(d), 64'hC3A5);
    wr(12'h430, 16'h1357); rd(12'h430, d); chk("R2 tx cfg", 64'(d), 64'h1357);
    wr(12'h110, 16'hFFFF); rd(12'h110, d); chk("R2 threshold width", 64'(d), 64'h00FF);
  endtask

  task automatic test_status();
    logic [15:0] d;
    @(negedge clk); stat_set = 16'h0011;
    @(negedge clk); stat_set = 16'h0100;
    @(negedge clk); stat_set = 16'h0000;
    chk("R6 masked no irq", 64'(irq), 64'd0);
    wr(12'h210, 16'hFEFF);
    chk("R6 unmasked irq", 64'(irq), 64'd1);
    // clearing read with a new event in the same cycle
    @(negedge clk); addr = 12'h200; rd_en = 1'b1; stat_set = 16'h0004;
    @(negedge clk); rd_en = 1'b0; stat_set = 16'h0000; d = rdata;
    chk("R3 status accumulate", 64'(d), 64'h0111);
    chk("R6 irq after clear", 64'(irq), 64'd0);
    rd(12'h200, d); chk("R4 concurrent event kept", 64'(d), 64'h0004);
    rd(12'h200, d); chk("R3 status cleared", 64'(d), 64'h0000);
    wr(12'h210, 16'hFFFF);
  endtask

  task automatic sample(input logic [7:0] v);
    @(negedge clk); att_valid = 1'b1; att_val = v;
    @(negedge clk); att_valid = 1'b0;
  endtask

  task automatic test_peak();
    logic [15:0] d;
    sample(8'd5); sample(8'd3); sample(8'd4);
    rd(12'h4E0, d); chk("R5 peak max", 64'(d), 64'd5);
    rd(12'h4E0, d); chk("R5 peak cleared", 64'(d), 64'd0);
    sample(8'd9);
    @(negedge clk); addr = 12'h4E0; rd_en = 1'b1; att_valid = 1'b1; att_val = 8'd2;
    @(negedge clk); rd_en = 1'b0; att_valid = 1'b0; d = rdata;
    chk("R5 peak before clear", 64'(d), 64'd9);
    rd(12'h4E0, d); chk("R5 concurrent sample kept", 64'(d), 64'd2);
  endtask

  task automatic test_fifo();
    logic [15:0] d;
    wr(12'h120, 16'h000B);
    chk("R7 rx enable", 64'(rx_fifo_en), 64'd1);
    chk("R7 rx size", 64'(rx_fifo_size), 64'(size_of(8'd5)));
    wr(12'h100, 16'hFFFF);
    chk("R7 tx size max", 64'(tx_fifo_size), 64'(size_of(8'hFF)));
    chk("R7 tx enable", 64'(tx_fifo_en), 64'd1);
    rd(12'h100, d); chk("R2 fifo readback", 64'(d), 64'h01FF);
    wr(12'h100, 16'h0000);
    chk("R7 tx disable", 64'(tx_fifo_en), 64'd0);
  endtask

  task automatic test_txrst();
    logic [15:0] d;
    @(negedge clk); addr = 12'h420; wdata = 16'h0001; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk("R8 pulse high", 64'(tx_sw_rst), 64'd1);
    @(negedge clk);
    chk("R8 pulse ends", 64'(tx_sw_rst), 64'd0);
    rd(12'h420, d); chk("R8 reads zero", 64'(d), 64'd0);
  endtask

  task automatic test_filters();
    wr(12'h660, 16'hAAAA); wr(12'h670, 16'hBBBB); wr(12'h680, 16'hCCCC);
    chk("R9 station order", 64'(station_addr), 64'hAAAA_BBBB_CCCC);
    wr(12'h700, 16'h1111); wr(12'h710, 16'h2222);
    wr(12'h720, 16'h3333); wr(12'h730, 16'h4444);
    chk("R10 hash order", hash_bits, 64'h4444_3333_2222_1111);
  endtask

  task automatic test_counters();
    logic [15:0] d;
    wr(12'h6A0, 16'h1234); rd(12'h6A0, d); chk("R11 narrow counter", 64'(d), 64'h0034);
    wr(12'h6E0, 16'hFF81); rd(12'h6E0, d); chk("R11 narrow cve", 64'(d), 64'h0081);
    wr(12'h690, 16'h1234); rd(12'h690, d); chk("R11 frame counter", 64'(d), 64'h1234);
    wr(12'h500, 16'hBEEF); rd(12'h500, d); chk("R11 collision counter", 64'(d), 64'hBEEF);
    wr(12'h540, 16'h8001); rd(12'h540, d); chk("R11 seed", 64'(d), 64'h8001);
  endtask

  task automatic test_decode();
    logic [15:0] d;
    wr(12'h170, 16'h0000); rd(12'h170, d); chk("R12 chip id", 64'(d), 64'(ID));
    wr(12'h7F0, 16'hFFFF); rd(12'h7F0, d); chk("R13 unmapped read", 64'(d), 64'd0);
    wr(12'h668, 16'h0F0F);
    chk("R13 station untouched", 64'(station_addr), 64'hAAAA_BBBB_CCCC);
    chk("R13 hash untouched", hash_bits, 64'h4444_3333_2222_1111);
    rd(12'h000, d); chk("R13 xifc untouched", 64'(d), 64'hC3A5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_rw();
    test_status();
    test_peak();
    test_fifo();
    test_txrst();
    test_filters();
    test_counters();
    test_decode();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule